// File: doc/BRIEF.md
# Two-Wire Controller Indirect Register Bridge

This block gives a host one 64-bit command/status word through which it reaches the 8-bit internal registers of a two-wire serial controller. The host writes a single word carrying a launch flag, a read flag, an opcode, a 3-bit internal address and a data byte. The bridge then runs the internal access by itself and drops the launch flag when it is done. For a read, the register value is returned in the low byte of the same word, so the host needs only a write followed by polling reads.

The bridge holds the controller's internal register bank: data, control, clock-control and status. The serial engine outside the block reads the data, control and clock-control values from output ports and posts its status through a write strobe. A second opcode loads the clock high-period divider value directly. A soft-reset address puts the status back to the idle code and clears control.

The sequencer has three named states. `ST_IDLE` waits for a launch. `ST_WAIT` counts the access latency. `ST_COMMIT` performs the access and clears the flag. The transitions are: ST_IDLE→ST_WAIT on a host write with bit 63 set, ST_WAIT→ST_COMMIT when the latency counter reaches `ACC_LAT-2`, and ST_COMMIT→ST_IDLE unconditionally. Any other case holds the current state.

Top module: `twi_cmd_bridge`

## Requirements
- R1: A host write with bit 63 set, made while the bridge is idle, starts an operation, and bit 63 of `host_rdata` reads 1 from the next cycle. A host write with bit 63 clear has no effect.
- R2: Bit 63 reads 1 for exactly `ACC_LAT` (default 4) cycles after the launch edge, then reads 0.
- R3: A host write that arrives while bit 63 reads 1 is ignored. The running command's fields and its effect are unchanged.
- R4: Opcode 6 (bits 60:57) with bit 56 clear writes bits 7:0 to the internal register at bits 34:32: 1 = data (`data_q`), 2 = control (`ctl_q`), 3 = clock-control (`clkctl_q`). Addresses 0, 4, 5 and 6 change nothing.
- R5: Opcode 6 with bit 56 set returns in bits 7:0: address 1 = data, 2 = control, 3 = status, and 0 for any other address.
- R6: An opcode-6 write to address 7 sets the status to 0xF8 (idle) and clears control.
- R7: Opcode 4 loads bits 7:0 into the clock high-period value `thp_q`.
- R8: Any opcode other than 4 or 6 clears bit 63 after the same latency and changes no register.
- R9: `host_rdata` holds the launch flag at 63, opcode at 60:57, read flag at 56, internal address at 34:32 and the data byte at 7:0. After a write the data byte is the written byte, and after a read it is the read result. All other bits read 0.
- R10: After reset, `host_rdata` is 0, the data, control, clock-control and high-period registers are 0, and status is 0xF8.
- R11: `eng_stat_we` loads `eng_stat` into the status register, and a later status read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Command/status word read by the host |
| eng_stat_we | input | 1 | Serial engine status update strobe |
| eng_stat | input | 8 | Status code from the serial engine |
| data_q | output | 8 | Data register value |
| ctl_q | output | 8 | Control register value |
| clkctl_q | output | 8 | Clock-control register value |
| thp_q | output | 8 | Clock high-period divider value |

## Verification
A launch written before clock edge E0 makes bit 63 visible after E0. The flag then stays 1 through edge E0+ACC_LAT-1. Register outputs, the read byte and the cleared flag all appear together after edge E0+ACC_LAT. The bench drives on falling edges and samples bit 63 at every falling edge from E0 to E0+ACC_LAT. It checks the register ports and the returned word only at the falling edge after E0+ACC_LAT. For the busy case, a second write is injected so that it is sampled at E1, and its absence is then confirmed on the register ports and in the returned word.

// File: rtl/twi_br_pkg.sv
package twi_br_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_COMMIT = 2'd2
    } br_state_e;

    localparam int POS_VALID = 63;
    localparam int POS_RD    = 56;
    localparam int POS_OP    = 57;
    localparam int POS_IA    = 32;

    localparam logic [3:0] OP_CLKHI = 4'd4;
    localparam logic [3:0] OP_EXT   = 4'd6;

    localparam logic [2:0] IA_DATA    = 3'd1;
    localparam logic [2:0] IA_CTRL    = 3'd2;
    localparam logic [2:0] IA_CLKSTAT = 3'd3;
    localparam logic [2:0] IA_SRST    = 3'd7;

    localparam logic [7:0] STAT_IDLE = 8'hF8;

    typedef struct packed {
        logic       rd;
        logic [3:0] op;
        logic [2:0] ia;
        logic [7:0] dat;
    } br_cmd_t;

    function automatic logic [63:0] pack_status(input logic v, input br_cmd_t c);
        logic [63:0] w;
        w = '0;
        w[POS_VALID]           = v;
        w[POS_RD]              = c.rd;
        w[POS_OP +: 4]         = c.op;
        w[POS_IA +: 3]         = c.ia;
        w[7:0]                 = c.dat;
        return w;
    endfunction

endpackage

// File: rtl/twi_br_decode.sv
module twi_br_decode
    import twi_br_pkg::*;
(
    input  logic [63:0] word,
    output logic        launch,
    output br_cmd_t     cmd
);
    always_comb begin
        launch  = word[POS_VALID];
        cmd.rd  = word[POS_RD];
        cmd.op  = word[POS_OP +: 4];
        cmd.ia  = word[POS_IA +: 3];
        cmd.dat = word[7:0];
    end
endmodule

// File: rtl/twi_br_regbank.sv
module twi_br_regbank
    import twi_br_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          stat_we,
    input  logic [DW-1:0] stat_in,
    output logic [DW-1:0] data_q,
    output logic [DW-1:0] ctl_q,
    output logic [DW-1:0] clkctl_q
);
    localparam logic [DW-1:0] STAT_RST = DW'(STAT_IDLE);

    logic [DW-1:0] stat_q;
    logic          srst;

    assign srst = wr_en && (addr == IA_SRST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            ctl_q    <= '0;
            clkctl_q <= '0;
            stat_q   <= STAT_RST;
        end else begin
            if (srst) begin
                stat_q <= STAT_RST;
                ctl_q  <= '0;
            end else begin
                if (stat_we) stat_q <= stat_in;
                if (wr_en) begin
                    unique case (addr)
                        IA_DATA:    data_q   <= wdata;
                        IA_CTRL:    ctl_q    <= wdata;
                        IA_CLKSTAT: clkctl_q <= wdata;
                        default:    ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        unique case (addr)
            IA_DATA:    rdata = data_q;
            IA_CTRL:    rdata = ctl_q;
            IA_CLKSTAT: rdata = stat_q;
            default:    rdata = '0;
        endcase
    end

    // R6: soft reset lands on the idle status code and clears control
    a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (stat_q == STAT_RST) && (ctl_q == '0));

    // R11: an engine update without soft reset is taken as-is
    a_r11_stat_load: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !srst) |=> stat_q == $past(stat_in));
endmodule

// File: rtl/twi_cmd_bridge.sv
module twi_cmd_bridge
    import twi_br_pkg::*;
#(
    parameter int ACC_LAT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [63:0] host_wdata,
    output logic [63:0] host_rdata,
    input  logic        eng_stat_we,
    input  logic [7:0]  eng_stat,
    output logic [7:0]  data_q,
    output logic [7:0]  ctl_q,
    output logic [7:0]  clkctl_q,
    output logic [7:0]  thp_q
);
    localparam int             CW       = $clog2(ACC_LAT + 1);
    localparam logic [CW-1:0]  CNT_LAST = CW'(ACC_LAT - 2);

    br_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          valid_q;
    br_cmd_t       cmd_q, dec_cmd;
    logic          dec_launch;
    logic          bank_we;
    logic [7:0]    bank_rdata;
    logic          start;

    twi_br_decode u_dec (
        .word   (host_wdata),
        .launch (dec_launch),
        .cmd    (dec_cmd)
    );

    assign start   = host_we && dec_launch;
    assign bank_we = (state_q == ST_COMMIT) && (cmd_q.op == OP_EXT) && !cmd_q.rd;

    twi_br_regbank #(.DW(8)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bank_we),
        .addr     (cmd_q.ia),
        .wdata    (cmd_q.dat),
        .rdata    (bank_rdata),
        .stat_we  (eng_stat_we),
        .stat_in  (eng_stat),
        .data_q   (data_q),
        .ctl_q    (ctl_q),
        .clkctl_q (clkctl_q)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_WAIT;
            ST_WAIT:   if (cnt_q == CNT_LAST) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath / outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            valid_q <= 1'b0;
            cmd_q   <= '0;
            thp_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q   <= dec_cmd;
                        valid_q <= 1'b1;
                        cnt_q   <= '0;
                    end
                end
                ST_WAIT: cnt_q <= cnt_q + 1'b1;
                ST_COMMIT: begin
                    valid_q <= 1'b0;
                    if (cmd_q.op == OP_EXT && cmd_q.rd) cmd_q.dat <= bank_rdata;
                    if (cmd_q.op == OP_CLKHI) thp_q <= cmd_q.dat;
                end
                default: ;
            endcase
        end
    end

    assign host_rdata = pack_status(valid_q, cmd_q);

    // checker counter: cycles the flag has been up
    logic [CW-1:0] chk_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       chk_cnt <= '0;
        else if (valid_q) chk_cnt <= chk_cnt + 1'b1;
        else              chk_cnt <= '0;
    end

    // R1: idle launch raises the flag on the next cycle
    a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rdata[63] && host_we && host_wdata[63]) |=> host_rdata[63]);

    // R2: flag never stays up longer than the latency
    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[63] |-> chk_cnt < CW'(ACC_LAT));

    // R2: flag drops exactly at the latency
    a_r2_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[63] && chk_cnt == CW'(ACC_LAT - 1)) |=> !host_rdata[63]);

    // R3: a write while busy leaves the running opcode unchanged
    a_r3_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[63] && host_we) |=> $stable(host_rdata[60:57]));

    // R7: high-period load takes the command byte
    a_r7_clk_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && cmd_q.op == OP_CLKHI) |=> thp_q == $past(cmd_q.dat));
endmodule

// File: tb/twi_cmd_bridge_bench.sv
module twi_cmd_bridge_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        eng_stat_we = 1'b0;
    logic [7:0]  eng_stat = '0;
    logic [7:0]  data_q, ctl_q, clkctl_q, thp_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] m_data = 0, m_ctl = 0, m_clk = 0, m_stat = 8'hF8, m_thp = 0;

    localparam logic [63:0] JUNK = (64'h1 << 62) | (64'h1 << 61) |
                                   (64'h1FFFFF << 35) | (64'hFFFFFF << 8);

    twi_cmd_bridge #(.ACC_LAT(LAT)) u_twi_cmd_bridge (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .eng_stat_we(eng_stat_we), .eng_stat(eng_stat),
        .data_q(data_q), .ctl_q(ctl_q), .clkctl_q(clkctl_q), .thp_q(thp_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input bit v, input bit rd, input logic [3:0] op,
                                       input logic [2:0] ia, input logic [7:0] d);
        return ({63'b0, v} << 63) | ({63'b0, rd} << 56) | ({60'b0, op} << 57) |
               ({61'b0, ia} << 32) | {56'b0, d};
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd1: return m_data;
            3'd2: return m_ctl;
            3'd3: return m_stat;
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_write(input logic [2:0] a, input logic [7:0] v);
        case (a)
            3'd1: m_data = v;
            3'd2: m_ctl = v;
            3'd3: m_clk = v;
            3'd7: begin m_stat = 8'hF8; m_ctl = 8'h00; end
            default: ;
        endcase
    endtask

    task automatic do_cmd(input logic [63:0] w, input bit inj, input logic [63:0] iw,
                          output logic [63:0] rb, output bit tim_ok);
        @(negedge clk); host_we = 1'b1; host_wdata = w;
        @(negedge clk); host_we = inj; host_wdata = iw;
        tim_ok = host_rdata[63];
        for (int k = 1; k < LAT; k++) begin
            @(negedge clk); host_we = 1'b0;
            tim_ok &= host_rdata[63];
        end
        @(negedge clk); host_we = 1'b0;
        tim_ok &= !host_rdata[63];
        rb = host_rdata;
    endtask

    task automatic check_regs(input string req);
        check({data_q, ctl_q, clkctl_q, thp_q} == {m_data, m_ctl, m_clk, m_thp}, req,
              {32'b0, data_q, ctl_q, clkctl_q, thp_q}, {32'b0, m_data, m_ctl, m_clk, m_thp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] rb;
        bit tok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(host_rdata == 64'h0, "R10 readback", host_rdata, 64'h0);
        check_regs("R10 regs");

        // R10 status after reset via read
        do_cmd(mk(1, 1, 4'd6, 3'd3, 8'h00), 0, 0, rb, tok);
        check(rb[7:0] == 8'hF8, "R10 status", rb, 64'hF8);

        // R1 write with flag clear: nothing happens
        @(negedge clk); host_we = 1'b1; host_wdata = mk(0, 0, 4'd6, 3'd2, 8'hAA);
        @(negedge clk); host_we = 1'b0;
        check(host_rdata[63] == 1'b0, "R1 no launch flag", host_rdata, 64'h0);
        repeat (LAT + 1) @(negedge clk);
        check_regs("R1 no launch regs");

        // R4/R2/R9 write sweep over all addresses, junk in unused bits
        for (int a = 0; a < 8; a++) begin
            logic [7:0] v;
            v = 8'(a * 29 + 53);
            do_cmd(mk(1, 0, 4'd6, 3'(a), v) | JUNK, 0, 0, rb, tok);
            m_write(3'(a), v);
            check(tok, "R2 flag timing write", {63'b0, tok}, 64'h1);
            check_regs("R4 write sweep");
            check(rb == mk(0, 0, 4'd6, 3'(a), v), "R9 write readback", rb, mk(0, 0, 4'd6, 3'(a), v));
        end

        // R5 read sweep over all addresses
        for (int a = 0; a < 8; a++) begin
            do_cmd(mk(1, 1, 4'd6, 3'(a), 8'h77) | JUNK, 0, 0, rb, tok);
            check(tok, "R2 flag timing read", {63'b0, tok}, 64'h1);
            check(rb == mk(0, 1, 4'd6, 3'(a), m_read(3'(a))), "R5 read sweep", rb,
                  mk(0, 1, 4'd6, 3'(a), m_read(3'(a))));
        end

        // restore control then R11 engine status, R6 soft reset
        do_cmd(mk(1, 0, 4'd6, 3'd2, 8'h3C), 0, 0, rb, tok); m_write(3'd2, 8'h3C);
        @(negedge clk); eng_stat_we = 1'b1; eng_stat = 8'h28;
        @(negedge clk); eng_stat_we = 1'b0; m_stat = 8'h28;
        do_cmd(mk(1, 1, 4'd6, 3'd3, 8'h00), 0, 0, rb, tok);
        check(rb[7:0] == 8'h28, "R11 status read", rb, 64'h28);
        do_cmd(mk(1, 0, 4'd6, 3'd7, 8'h00), 0, 0, rb, tok); m_write(3'd7, 8'h00);
        check_regs("R6 ctl cleared");
        do_cmd(mk(1, 1, 4'd6, 3'd3, 8'h00), 0, 0, rb, tok);
        check(rb[7:0] == 8'hF8, "R6 status idle", rb, 64'hF8);

        // R7 clock high-period loads
        for (int i = 0; i < 4; i++) begin
            logic [7:0] t;
            t = 8'(6 << i);
            do_cmd(mk(1, 0, 4'd4, 3'd0, t), 0, 0, rb, tok);
            m_thp = t;
            check(tok, "R7 timing", {63'b0, tok}, 64'h1);
            check_regs("R7 thp load");
        end

        // R8 unsupported opcodes
        for (int op = 0; op < 16; op++) begin
            if (op == 4 || op == 6) continue;
            do_cmd(mk(1, 0, 4'(op), 3'd2, 8'hE1), 0, 0, rb, tok);
            check(tok, "R8 flag clears", {63'b0, tok}, 64'h1);
            check_regs("R8 no side effect");
        end

        // R3 busy write ignored
        do_cmd(mk(1, 0, 4'd6, 3'd2, 8'h11), 1, mk(1, 0, 4'd4, 3'd1, 8'h99), rb, tok);
        m_write(3'd2, 8'h11);
        check(tok, "R3 timing", {63'b0, tok}, 64'h1);
        check_regs("R3 busy ignored regs");
        check(rb == mk(0, 0, 4'd6, 3'd2, 8'h11), "R3 busy ignored readback", rb, mk(0, 0, 4'd6, 3'd2, 8'h11));
        repeat (LAT + 2) @(negedge clk);
        check(host_rdata[63] == 1'b0, "R3 no late launch", host_rdata, 64'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule